// File: doc/BRIEF.md
# Byte FIFO with Occupancy Level and Low-Water Interrupt

This block holds up to 256 bytes in arrival order for one direction of a serial port. Bytes go in through a push strobe and come out through a pop strobe. The oldest byte always appears on the pop data output. The block counts exactly how many bytes it holds. Software reads that count through an 8-bit level register on a single-cycle register port. Because the field is only 8 bits wide, the two top occupancies of 255 and 256 both read as 0xFF.

When built as the transmit instance, the block also holds an 8-bit write-only threshold. It drives a level-sensitive interrupt for as long as the stored byte count is below that threshold. Software can use it to refill the queue before it runs dry. The receive instance is built with the same parameter set and the threshold switched off. It keeps only the level register.

Top module: `fifo_level_trig`

## Requirements
- R1: After reset the FIFO is empty, `empty` is 1, `full` is 0, the level reads 0x00, the threshold is 0x00 and `txIrq` is 0.
- R2: An accepted push alone adds one to the occupancy and an accepted pop alone removes one. The level register (`regSel`=0) reads the occupancy from the clock edge that follows.
- R3: A push and a pop accepted in the same cycle leave the occupancy unchanged. When the FIFO is full only the pop is accepted. When it is empty only the push is accepted.
- R4: A push while `full` is 1 is ignored: the occupancy and the stored bytes do not change, and `pushErr` is 1 in that cycle.
- R5: A pop while `empty` is 1 is ignored: the occupancy does not change, and `popErr` is 1 in that cycle.
- R6: `popData` always shows the oldest stored byte, so bytes leave in the order they were pushed.
- R7: The level register reads the low 8 bits of the occupancy, except at an occupancy of 256, where it saturates to 0xFF.
- R8: A cycle with `regWrEn`=1 and `regSel`=1 loads `regWrData` into the threshold; any value from 0x00 to 0xFF is accepted. Reads with `regSel`=1 return 0x00 because the threshold is write-only.
- R9: `txIrq` is 1 exactly when the occupancy is below the threshold. It is re-evaluated every cycle against the current values of both, so a threshold of 0x00 never raises it.
- R10: `full` is 1 exactly at an occupancy of 256 and `empty` is 1 exactly at an occupancy of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Push request for `pushData` |
| pushData | input | 8 | Byte to store |
| popReq | input | 1 | Pop request for the oldest byte |
| popData | output | 8 | Oldest stored byte |
| full | output | 1 | FIFO holds 256 bytes |
| empty | output | 1 | FIFO holds no bytes |
| pushErr | output | 1 | Push refused because the FIFO is full |
| popErr | output | 1 | Pop refused because the FIFO is empty |
| regSel | input | 1 | Register select: 0 = level, 1 = threshold |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| txIrq | output | 1 | Occupancy is below the threshold |

## Verification
The assertions assume that `pushValid`, `popReq` and the register strobes are stable around each rising edge and never unknown after reset. They also assume that a register write is not mixed with expectations on the level register in the same cycle. The bench drives every input on the falling edge and returns it to idle between operations. It raises `regWrEn` only together with `regSel`=1, so each property sees clean, single-meaning strobes. Overflow and underflow are reached on purpose, so the assertions that guard the pointers run at both boundaries.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;

  // Strobes from the control decision to the datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic trigWrite;
  } fifoStrobes_t;

endpackage

// File: rtl/fifo_lvl_ctrl.sv
module fifo_lvl_ctrl
  import fifo_lvl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushValid,
  input  logic         popReq,
  input  logic         full,
  input  logic         empty,
  input  logic         regSel,
  input  logic         regWrEn,
  output fifoStrobes_t strb,
  output logic         pushErr,
  output logic         popErr
);

  always_comb begin
    strb.doPush    = pushValid && !full;
    strb.doPop     = popReq && !empty;
    strb.trigWrite = regWrEn && regSel;
    pushErr        = pushValid && full;
    popErr         = popReq && empty;
  end

  // R4 / R5: a refused request must never reach the datapath as a strobe
  a_r4_err_blocks_push: assert property (@(posedge clk) disable iff (!rstN)
    pushErr |-> !strb.doPush);
  a_r5_err_blocks_pop: assert property (@(posedge clk) disable iff (!rstN)
    popErr |-> !strb.doPop);

endmodule

// File: rtl/fifo_lvl_data.sv
module fifo_lvl_data
  import fifo_lvl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int LVL_W  = 8,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [DATA_W-1:0] pushData,
  input  logic [LVL_W-1:0]  regWrData,
  output logic [DATA_W-1:0] popData,
  output logic              full,
  output logic              empty,
  output logic [LVL_W-1:0]  level,
  output logic              trigIrq
);

  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int CNT_W   = ADDR_W + 1;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [CNT_W-1:0]  count;
  logic [LVL_W-1:0]  trigReg;

  always_ff @(posedge clk) begin
    if (strb.doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.doPush) wrPtr <= wrPtr + 1'b1;
      if (strb.doPop)  rdPtr <= rdPtr + 1'b1;
      if (strb.doPush && !strb.doPop)      count <= count + 1'b1;
      else if (strb.doPop && !strb.doPush) count <= count - 1'b1;
    end
  end

  assign popData = mem[rdPtr];
  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);

  always_comb begin
    if (count > CNT_W'(LVL_MAX)) level = LVL_W'(LVL_MAX);
    else                         level = count[LVL_W-1:0];
  end

  generate
    if (IS_TX) begin : g_trig
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               trigReg <= '0;
        else if (strb.trigWrite) trigReg <= regWrData;
      end
      assign trigIrq = (count < CNT_W'(trigReg));
    end else begin : g_noTrig
      assign trigReg = '0;
      assign trigIrq = 1'b0;
    end
  endgenerate

  // R4 / R5: pointer updates only when there is room or data
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush && !strb.doPop |-> !full);
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop |-> !empty);
  // R3: balanced traffic keeps the occupancy
  a_r3_balanced_hold: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPush && strb.doPop |=> $stable(count));
  // R8: the threshold moves only on a select-qualified write
  a_r8_trig_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.trigWrite |=> $stable(trigReg));
  // R7: a full FIFO reports the saturated level
  a_r7_full_saturates: assert property (@(posedge clk) disable iff (!rstN)
    full |-> level == LVL_W'(LVL_MAX));
  // R10: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

endmodule

// File: rtl/fifo_level_trig.sv
module fifo_level_trig
  import fifo_lvl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  parameter int LVL_W  = 8,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              full,
  output logic              empty,
  output logic              pushErr,
  output logic              popErr,
  input  logic              regSel,
  input  logic              regWrEn,
  input  logic [LVL_W-1:0]  regWrData,
  output logic [LVL_W-1:0]  regRdData,
  output logic              txIrq
);

  fifoStrobes_t    strb;
  logic [LVL_W-1:0] level;

  fifo_lvl_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .popReq    (popReq),
    .full      (full),
    .empty     (empty),
    .regSel    (regSel),
    .regWrEn   (regWrEn),
    .strb      (strb),
    .pushErr   (pushErr),
    .popErr    (popErr)
  );

  fifo_lvl_data #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .LVL_W  (LVL_W),
    .IS_TX  (IS_TX)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pushData  (pushData),
    .regWrData (regWrData),
    .popData   (popData),
    .full      (full),
    .empty     (empty),
    .level     (level),
    .trigIrq   (txIrq)
  );

  // Threshold is write-only: its address reads as zero
  assign regRdData = regSel ? '0 : level;

  // R9: a zero-threshold interrupt cannot be pending after the write
  a_r9_zero_trig_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigWrite && regWrData == '0 |=> !txIrq);

endmodule

// File: tb/test_fifo_level_trig.sv
module test_fifo_level_trig;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {push, pop, data[7:0], expected level[7:0]}
  localparam logic [17:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 8'hA5, 8'd1},
    {1'b1, 1'b0, 8'h3C, 8'd2},
    {1'b1, 1'b1, 8'h77, 8'd2},
    {1'b0, 1'b1, 8'h00, 8'd1},
    {1'b0, 1'b1, 8'h00, 8'd0},
    {1'b0, 1'b1, 8'h00, 8'd0},
    {1'b1, 1'b1, 8'h11, 8'd1},
    {1'b0, 1'b1, 8'h00, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 1'b0;
  logic [7:0] pushData = '0;
  logic       popReq = 1'b0;
  logic [7:0] popData;
  logic       full, empty, pushErr, popErr;
  logic       regSel = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       txIrq;

  int nChecks = 0;
  int nFails  = 0;
  logic seenPushErr, seenPopErr;
  logic [7:0] seenPopData;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_level_trig i_fifo_level_trig (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .popData(popData), .full(full), .empty(empty),
    .pushErr(pushErr), .popErr(popErr), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .txIrq(txIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle of traffic: drive on falling edge, capture combinational
  // flags before the rising edge, leave the bench 1 ns after it.
  task automatic op(input logic p, input logic q, input logic [7:0] d);
    @(negedge clk);
    pushValid = p; popReq = q; pushData = d;
    #1;
    seenPushErr = pushErr; seenPopErr = popErr; seenPopData = popData;
    @(posedge clk); #1;
    pushValid = 1'b0; popReq = 1'b0;
  endtask

  task automatic writeTrig(input logic [7:0] v);
    @(negedge clk);
    regSel = 1'b1; regWrEn = 1'b1; regWrData = v;
    @(posedge clk); #1;
    regWrEn = 1'b0; regSel = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #(CLK_PERIOD);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(2*CLK_PERIOD + 2);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 level", regRdData, 8'h00);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 txIrq", txIrq, 0);

    // Vector walk: R2 / R3 / R5
    for (int i = 0; i < NVEC; i++) begin
      op(VECS[i][17], VECS[i][16], VECS[i][15:8]);
      chk("R2 R3 vector level", regRdData, VECS[i][7:0]);
    end

    // R6 order after mixed traffic
    op(1'b1, 1'b0, 8'hC1);
    op(1'b1, 1'b0, 8'hC2);
    op(1'b0, 1'b1, 8'h00);
    chk("R6 first out", seenPopData, 8'hC1);
    chk("R6 next head", popData, 8'hC2);
    op(1'b0, 1'b1, 8'h00);

    // R5 underflow flag
    op(1'b0, 1'b1, 8'h00);
    chk("R5 popErr", seenPopErr, 1);
    chk("R5 level held", regRdData, 8'h00);

    // R8 / R9 threshold
    writeTrig(8'd4);
    regSel = 1'b1; #1;
    chk("R8 write-only reads zero", regRdData, 8'h00);
    regSel = 1'b0; #1;
    chk("R9 irq below threshold", txIrq, 1);
    for (int i = 0; i < 3; i++) op(1'b1, 1'b0, 8'(i));
    chk("R9 irq at 3 of 4", txIrq, 1);
    op(1'b1, 1'b0, 8'h03);
    chk("R9 irq clear at 4", txIrq, 0);
    op(1'b0, 1'b1, 8'h00);
    chk("R9 irq again at 3", txIrq, 1);
    writeTrig(8'd0);
    chk("R9 zero threshold quiet", txIrq, 0);
    writeTrig(8'd2);
    chk("R9 reevaluated on new threshold", txIrq, 0);

    // R10 / R7 / R4 fill to depth
    doReset();
    chk("R1 threshold cleared by reset", txIrq, 0);
    for (int i = 0; i < 255; i++) op(1'b1, 1'b0, 8'(i) ^ 8'h5A);
    chk("R7 level at 255", regRdData, 8'hFF);
    chk("R10 not full at 255", full, 0);
    op(1'b1, 1'b0, 8'hFF ^ 8'h5A);
    chk("R7 level saturates at 256", regRdData, 8'hFF);
    chk("R10 full at 256", full, 1);
    op(1'b1, 1'b0, 8'hEE);
    chk("R4 pushErr", seenPushErr, 1);
    chk("R4 still full", full, 1);
    chk("R4 head unchanged", popData, 8'h5A);
    // R3 push+pop when full: only the pop is taken
    op(1'b1, 1'b1, 8'hEE);
    chk("R3 full pop only", full, 0);
    chk("R3 level 255", regRdData, 8'hFF);
    writeTrig(8'hFF);
    chk("R9 not below at 255", txIrq, 0);
    for (int i = 1; i < 256; i++) begin
      op(1'b0, 1'b1, 8'h00);
      chk("R6 drain order", seenPopData, 8'(i) ^ 8'h5A);
      if (i == 1) chk("R9 irq at 254", txIrq, 1);
      if (i == 2) chk("R2 level 253", regRdData, 8'd253);
    end
    chk("R10 empty after drain", empty, 1);
    chk("R2 level zero", regRdData, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule